// File: doc/BRIEF.md
# Multiplexed-Bus Memory Decoder

This block connects a processor whose low address byte and data byte share one set of eight lines to a small memory system. During the first clock of every machine cycle the processor raises an address-latch strobe. The block captures the byte on the shared lines at that edge and keeps it while the strobe is low. It joins that byte to the high address byte, which has its own lines, to form a 16-bit address.

The top three address bits go through a 3-to-8 decode. The decode is enabled only when the memory/IO status line reads 0, meaning a memory access. Code 000 selects an 8K ROM. Code 001 selects an 8K RAM. The other six codes select nothing. A behavioural ROM, whose contents are computed from the address, and a behavioural RAM sit behind the two selects. This allows reads and writes to be checked end to end.

The block drives the shared lines back toward the processor through a separate output-enable. When it does not drive them, the lines read as all ones, as a pull-up would give.

Top module: `mux_bus_mem_decoder`

## Requirements
- R1: On a rising clock edge with `ale_i` high, the byte on `ad_i` is captured. From the following cycle, `addr_o` equals {`addr_hi_i`, captured byte}.
- R2: While `ale_i` is low, the captured low byte does not change, even when `ad_i` changes.
- R3: With `io_m_i`=0 and address bits 15..13 = 000 (0000h–1FFFh), `rom_sel_o` is 1. A read returns the ROM byte (A[7:0] XOR {000, A[12:8]} XOR A5h).
- R4: With `io_m_i`=0 and address bits 15..13 = 001 (2000h–3FFFh), `ram_sel_o` is 1. A read returns the last byte written to that RAM location.
- R5: With `io_m_i`=1, neither select is asserted, no write changes the RAM, and `ad_oe_o` stays 0.
- R6: Addresses 4000h–FFFFh assert no select, and a read from them returns FFh.
- R7: `ad_oe_o` is 1 only when a select is active, `io_m_i`=0 and `rd_n_i`=0. When `ad_oe_o` is 0, `ad_out_o` is FFh.
- R8: A write with `wr_n_i` low into the ROM range does not change any ROM byte.
- R9: A RAM write happens on a rising edge with `ram_sel_o`=1, `wr_n_i`=0 and `ale_i`=0. It stores `ad_i` at index A[RAM_AW-1:0], so the storage repeats across the 8K window.
- R10: After reset the captured low byte is 00h and every RAM byte reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale_i | input | 1 | Address-latch strobe, high in the first clock of a cycle |
| io_m_i | input | 1 | Status line: 0 = memory access, 1 = IO access |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe |
| addr_hi_i | input | 8 | High address byte |
| ad_i | input | 8 | Shared lines as driven by the processor (address, then write data) |
| ad_out_o | output | 8 | Value the block puts on the shared lines |
| ad_oe_o | output | 1 | Output-enable for `ad_out_o` |
| addr_o | output | 16 | Demultiplexed 16-bit address |
| rom_sel_o | output | 1 | ROM chip select, active high |
| ram_sel_o | output | 1 | RAM chip select, active high |

## Verification
A wrong captured low byte appears on `addr_o` in the cycle after the strobe edge. It also sends any RAM read in that cycle to the wrong index. A lost write, or a write let through for an IO cycle or the ROM range, stays hidden until that location is read back, possibly many cycles later. For this reason the random stream reads back random locations and compares them against a bench model. A wrong decode shows in the same cycle on the selects, and on `ad_oe_o` while the read strobe is low.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int BLK_AW = 13;
    localparam int CODE_W = ADDR_W - BLK_AW;
    localparam int NUM_CODES = 1 << CODE_W;
    localparam int ROM_CODE = 0;
    localparam int RAM_CODE = 1;
    localparam logic [DATA_W-1:0] FLOAT_BYTE = '1;

    function automatic logic [DATA_W-1:0] rom_byte(input logic [BLK_AW-1:0] a);
        return a[7:0] ^ {3'b000, a[12:8]} ^ 8'hA5;
    endfunction
endpackage

// File: rtl/mbd_low_latch.sv
module mbd_low_latch
    import mbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_i,
    input  logic [DATA_W-1:0] ad_i,
    output logic [DATA_W-1:0] low_o
);
    typedef struct packed {
        logic [DATA_W-1:0] low;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ale_i) st_d.low = ad_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign low_o = st_q.low;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_i |=> $stable(low_o));
    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ale_i |=> low_o == $past(ad_i));
endmodule

// File: rtl/mbd_map_decode.sv
module mbd_map_decode
    import mbd_pkg::*;
(
    input  logic              io_m_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              rom_sel_o,
    output logic              ram_sel_o
);
    logic [NUM_CODES-1:0] line;

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_line
        assign line[g] = !io_m_i && (code_i == CODE_W'(g));
    end

    assign rom_sel_o = line[ROM_CODE];
    assign ram_sel_o = line[RAM_CODE];

    always_comb begin
        p_one_line_r6: assert ($onehot0(line));
        p_io_quiet_r5: assert (!(io_m_i && (rom_sel_o || ram_sel_o)));
    end
endmodule

// File: rtl/mbd_mem_model.sv
module mbd_mem_model
    import mbd_pkg::*;
#(
    parameter int RAM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BLK_AW-1:0] addr_i,
    input  logic              rom_sel_i,
    input  logic              ram_sel_i,
    input  logic              ale_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              oe_o
);
    localparam int DEPTH = 1 << RAM_AW;

    logic [DATA_W-1:0] ram_d [DEPTH];
    logic [DATA_W-1:0] ram_q [DEPTH];
    logic [RAM_AW-1:0] idx;
    logic              we;

    assign idx = addr_i[RAM_AW-1:0];
    assign we  = ram_sel_i && !wr_n_i && !ale_i;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) ram_d[i] = ram_q[i];
        if (we) ram_d[idx] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ram_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) ram_q[i] <= ram_d[i];
        end
    end

    always_comb begin
        oe_o    = (rom_sel_i || ram_sel_i) && !rd_n_i;
        rdata_o = FLOAT_BYTE;
        if (oe_o) rdata_o = rom_sel_i ? rom_byte(addr_i) : ram_q[idx];
    end

    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ram_q[$past(idx)] == $past(wdata_i));
endmodule

// File: rtl/mux_bus_mem_decoder.sv
module mux_bus_mem_decoder
    import mbd_pkg::*;
#(
    parameter int RAM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_i,
    input  logic              io_m_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic [7:0]        addr_hi_i,
    input  logic [7:0]        ad_i,
    output logic [7:0]        ad_out_o,
    output logic              ad_oe_o,
    output logic [15:0]       addr_o,
    output logic              rom_sel_o,
    output logic              ram_sel_o
);
    logic [DATA_W-1:0] low_q;

    mbd_low_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .ale_i (ale_i),
        .ad_i  (ad_i),
        .low_o (low_q)
    );

    assign addr_o = {addr_hi_i, low_q};

    mbd_map_decode u_dec (
        .io_m_i    (io_m_i),
        .code_i    (addr_o[ADDR_W-1:BLK_AW]),
        .rom_sel_o (rom_sel_o),
        .ram_sel_o (ram_sel_o)
    );

    mbd_mem_model #(.RAM_AW(RAM_AW)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr_o[BLK_AW-1:0]),
        .rom_sel_i (rom_sel_o),
        .ram_sel_i (ram_sel_o),
        .ale_i     (ale_i),
        .rd_n_i    (rd_n_i),
        .wr_n_i    (wr_n_i),
        .wdata_i   (ad_i),
        .rdata_o   (ad_out_o),
        .oe_o      (ad_oe_o)
    );

    p_drive_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe_o |-> (!rd_n_i && !io_m_i && (rom_sel_o || ram_sel_o)));
    p_idle_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ad_oe_o |-> ad_out_o == 8'hFF);
endmodule

// File: tb/mux_bus_mem_decoder_tb.sv
module mux_bus_mem_decoder_tb_top;
    localparam int RAM_AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ale = 1'b0, io_m = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] addr_hi = '0, ad = '0;
    logic [7:0] ad_out;
    logic ad_oe, rom_sel, ram_sel;
    logic [15:0] addr;

    int checks = 0, errors = 0;
    logic [7:0] model [1 << RAM_AW];

    always #2.5 clk = ~clk;

    mux_bus_mem_decoder #(.RAM_AW(RAM_AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ale_i(ale), .io_m_i(io_m), .rd_n_i(rd_n),
        .wr_n_i(wr_n), .addr_hi_i(addr_hi), .ad_i(ad), .ad_out_o(ad_out),
        .ad_oe_o(ad_oe), .addr_o(addr), .rom_sel_o(rom_sel), .ram_sel_o(ram_sel)
    );

    function automatic logic [7:0] exp_rom(input logic [15:0] a);
        return a[7:0] ^ {3'b000, a[12:8]} ^ 8'hA5;
    endfunction

    function automatic logic [7:0] exp_read(input logic [15:0] a, input logic iom);
        if (iom) return 8'hFF;
        if (a[15:13] == 3'd0) return exp_rom(a);
        if (a[15:13] == 3'd1) return model[a[RAM_AW-1:0]];
        return 8'hFF;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // first clock: strobe high, low byte on shared lines
    task automatic t1(input logic [15:0] a, input logic iom);
        @(negedge clk);
        addr_hi = a[15:8]; ad = a[7:0]; ale = 1'b1; io_m = iom; rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        ale = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] a, input logic iom, input logic [7:0] d);
        t1(a, iom);
        ad = d; wr_n = 1'b0;
        #1;
        chk("R1", addr, a);
        chk("R3", rom_sel, !iom && a[15:13] == 3'd0);
        chk("R4", ram_sel, !iom && a[15:13] == 3'd1);
        @(negedge clk);
        @(negedge clk);
        wr_n = 1'b1;
        if (!iom && a[15:13] == 3'd1) model[a[RAM_AW-1:0]] = d;
    endtask

    task automatic do_read(input logic [15:0] a, input logic iom, input string req);
        logic [7:0] e;
        t1(a, iom);
        ad = 8'($urandom); rd_n = 1'b0;
        #1;
        e = exp_read(a, iom);
        chk("R2", addr, a);
        chk(req, ad_out, e);
        chk("R7", ad_oe, !iom && a[15:14] == 2'b00);
        @(negedge clk);
        ad = 8'($urandom);
        #1;
        chk("R2", addr, a);
        @(negedge clk);
        rd_n = 1'b1;
        #1;
        chk("R7", {ad_oe, ad_out}, {1'b0, 8'hFF});
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < (1 << RAM_AW); i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R10", addr, 16'h0000);
        rst_n = 1'b1;
        // R10: RAM starts at zero
        do_read(16'h2000, 1'b0, "R10");
        do_read(16'h3FFF, 1'b0, "R10");
        // R3: ROM range edges
        do_read(16'h0000, 1'b0, "R3");
        do_read(16'h1FFF, 1'b0, "R3");
        // R4: RAM write then read
        do_write(16'h2010, 1'b0, 8'h3C);
        do_read(16'h2010, 1'b0, "R4");
        // R9: mirrored storage
        do_write(16'h3F42, 1'b0, 8'h99);
        do_read(16'h2042, 1'b0, "R9");
        // R8: ROM write ignored
        do_write(16'h0123, 1'b0, 8'h00);
        do_read(16'h0123, 1'b0, "R8");
        // R5: IO cycle neither selects nor writes
        do_write(16'h2010, 1'b1, 8'hEE);
        do_read(16'h2010, 1'b1, "R5");
        do_read(16'h2010, 1'b0, "R5");
        // R6: unmapped edges
        do_read(16'h4000, 1'b0, "R6");
        do_read(16'hFFFF, 1'b0, "R6");
        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            logic iom;
            a = 16'($urandom);
            if ($urandom_range(3) != 0) a[15:13] = 3'($urandom_range(1));
            iom = ($urandom_range(7) == 0);
            if ($urandom_range(1) == 0) do_write(a, iom, 8'($urandom));
            else                        do_read(a, iom, "R4");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule